// File: doc/BRIEF.md
# Shared Multi-Tau Correlator Stage

This block is one four-lag stage of a multi-tau autocorrelator. A single arithmetic datapath serves `NCH` pixel channels in turn. The processing clock runs `NCH` times faster than the stage sample period, so every channel gets exactly one processing slot per period. Each channel's eight-deep sample history and its nine 64-bit running sums live in RAM, not in per-channel registers. Each accepted sample is read, multiplied against its delayed history, accumulated and written back through a short fixed-latency pipeline.

Samples arrive as a valid/ready stream. Beats are assigned to channels 0 to `NCH-1` in strict rotation. A beat is taken only on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is held low only while the block zeroes its RAMs after reset. The producer must hold a beat until it is taken, and idle cycles do not move the channel rotation.

`stage_en` travels with each beat. A beat taken while it is low uses up its channel slot and changes nothing. The sums stay readable at all times through a registered read port. Normalization and the front end that forms the stage input sit outside this block. Sample width is `4+STAGE` bits.

Top module: `corr_mt_stage`

## Requirements
- R1: After reset is released, `in_ready` stays low for exactly `NCH` clock edges while every sample history and sum is cleared. After that, every readable sum is zero.
- R2: Accepted beats go to channels 0, 1, …, `NCH-1` in order, then wrap back to channel 0.
- R3: For an enabled beat carrying x on a channel, selector k (0 to 3) adds x times the sample that channel received 5+k enabled beats earlier. Samples older than the history are counted as zero.
- R4: For an enabled beat, selector 4+k (k = 0 to 3) adds the sample the channel received 5+k enabled beats earlier.
- R5: For an enabled beat, selector 8 adds x itself.
- R6: A beat taken with `stage_en` low advances the channel rotation. It leaves every sum and the sample history of that channel unchanged.
- R7: `rd_data` gives the sum chosen by `rd_ch`/`rd_sel` one clock edge after they are sampled. Any selector above 8 reads zero.
- R8: The write-back of an accepted beat lands two edges after the accepting edge. A read sampled on that same edge returns the value from before the update.
- R9: A cycle with `in_valid` low does not advance the channel rotation. `in_ready` is never low after the clear has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock, `NCH` times the stage sample rate |
| rst_n | input | 1 | Active-low reset; starts the RAM clear |
| in_valid | input | 1 | Sample beat present |
| in_ready | output | 1 | Block can take a beat (low only during the clear) |
| in_data | input | 4+STAGE | Sample for the next channel in rotation |
| stage_en | input | 1 | Beat is accumulated when high, skipped when low |
| rd_ch | input | clog2(NCH) | Channel to read |
| rd_sel | input | 4 | Sum to read: 0-3 lag products, 4-7 delayed sums, 8 current sum |
| rd_data | output | 64 | Registered read result |

## Verification
Two functions can fall on the same edge: the read port sampling a channel's sum, and the pipeline writing that channel's new sum. The bench provokes this by pointing the read port at channel 0's current sum and then feeding channel 0 a beat. It samples `rd_data` after the first, second and third edges that follow. The first two reads must return the old total and the third the new one, which confirms both the two-edge write-back and read-before-write. Near-exhaustive sweeps over every channel and selector, with enabled, disabled, maximum-value and gapped frames, are judged against sums computed arithmetically in the bench.

// File: rtl/corr_mt_pkg.sv
package corr_mt_pkg;
  localparam int ACC_W    = 64;
  localparam int NLAG     = 4;
  localparam int NTAP     = 8;
  localparam int NACC     = 2 * NLAG + 1;
  localparam int SEL_W    = 4;
  localparam int LAG_TAP0 = NTAP - NLAG;
  typedef logic [ACC_W-1:0] acc_t;
endpackage

// File: rtl/corr_tap_ram.sv
module corr_tap_ram #(
  parameter int NCH = 256,
  parameter int DW  = 7,
  localparam int AW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] mem [NCH];

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
    if (we)    mem[wr_addr] <= wr_data;
  end
endmodule

// File: rtl/corr_acc_bank.sv
module corr_acc_bank #(
  parameter int NCH  = 256,
  parameter int NACC = 9,
  parameter int ACC_W = 64,
  parameter int SEL_W = 4,
  localparam int AW = $clog2(NCH),
  localparam int WW = NACC * ACC_W
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WW-1:0]    rd_q,
  input  logic             we,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WW-1:0]    wr_data,
  input  logic [AW-1:0]    host_addr,
  input  logic [SEL_W-1:0] host_sel,
  output logic [ACC_W-1:0] host_q
);
  logic [WW-1:0] mem [NCH];

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
    if (int'(host_sel) < NACC)
      host_q <= mem[host_addr][int'(host_sel)*ACC_W +: ACC_W];
    else
      host_q <= '0;
    if (we) mem[wr_addr] <= wr_data;
  end
endmodule

// File: rtl/corr_lag_lane.sv
module corr_lag_lane #(
  parameter int DW    = 7,
  parameter int ACC_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [DW-1:0]    x,
  input  logic [DW-1:0]    tap,
  input  logic [ACC_W-1:0] lag_old,
  input  logic [ACC_W-1:0] dly_old,
  output logic [ACC_W-1:0] lag_new,
  output logic [ACC_W-1:0] dly_new
);
  logic [2*DW-1:0] prod_q;
  logic [DW-1:0]   tap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_q <= '0;
      tap_q  <= '0;
    end else if (ld) begin
      prod_q <= x * tap;
      tap_q  <= tap;
    end
  end

  assign lag_new = lag_old + ACC_W'(prod_q);
  assign dly_new = dly_old + ACC_W'(tap_q);
endmodule

// File: rtl/corr_mt_stage.sv
module corr_mt_stage
  import corr_mt_pkg::*;
#(
  parameter int NCH   = 256,
  parameter int STAGE = 3,
  localparam int DW   = 4 + STAGE,
  localparam int CW   = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic             stage_en,
  input  logic [CW-1:0]    rd_ch,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [ACC_W-1:0] rd_data
);
  localparam logic [CW-1:0] LAST = CW'(NCH - 1);

  logic          clearing;
  logic [CW-1:0] clr_cnt, ch_cnt;
  logic          accept;
  logic          s1_valid, s1_en, s2_valid, s2_en;
  logic [CW-1:0] s1_ch, s2_ch;
  logic [DW-1:0] s1_x, s2_x;
  logic [NTAP-1:0][DW-1:0] tap_q, tap_wd;
  logic [NTAP-2:0][DW-1:0] s2_tap;
  logic          wb_we;
  logic [CW-1:0] wb_addr;
  logic [NACC*ACC_W-1:0] acc_old, acc_wd;
  acc_t          acc_old_a [NACC];
  acc_t          acc_new_a [NACC];

  assign in_ready = ~clearing;
  assign accept   = in_valid & in_ready;
  assign wb_we    = clearing | (s2_valid & s2_en);
  assign wb_addr  = clearing ? clr_cnt : s2_ch;

  // Clear sweep, channel rotation and pipeline control.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clearing <= 1'b1;
      clr_cnt  <= '0;
      ch_cnt   <= '0;
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
      s1_en    <= 1'b0;
      s2_en    <= 1'b0;
      s1_ch    <= '0;
      s2_ch    <= '0;
      s1_x     <= '0;
      s2_x     <= '0;
    end else begin
      if (clearing) begin
        clr_cnt <= (clr_cnt == LAST) ? '0 : clr_cnt + CW'(1);
        if (clr_cnt == LAST) clearing <= 1'b0;
      end
      if (accept) ch_cnt <= (ch_cnt == LAST) ? '0 : ch_cnt + CW'(1);
      s1_valid <= accept;
      s1_ch    <= ch_cnt;
      s1_x     <= in_data;
      s1_en    <= stage_en;
      s2_valid <= s1_valid;
      s2_ch    <= s1_ch;
      s2_x     <= s1_x;
      s2_en    <= s1_en;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_valid) s2_tap <= tap_q[NTAP-2:0];
  end

  // Sample history: one RAM per tap, shifted on write-back.
  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    if (t == 0) begin : g_head
      assign tap_wd[t] = clearing ? '0 : s2_x;
    end else begin : g_body
      assign tap_wd[t] = clearing ? '0 : s2_tap[t-1];
    end
    corr_tap_ram #(.NCH(NCH), .DW(DW)) u_tap (
      .clk    (clk),
      .rd_en  (accept),
      .rd_addr(ch_cnt),
      .rd_q   (tap_q[t]),
      .we     (wb_we),
      .wr_addr(wb_addr),
      .wr_data(tap_wd[t])
    );
  end

  corr_acc_bank #(.NCH(NCH), .NACC(NACC), .ACC_W(ACC_W), .SEL_W(SEL_W)) u_acc (
    .clk      (clk),
    .rd_en    (s1_valid),
    .rd_addr  (s1_ch),
    .rd_q     (acc_old),
    .we       (wb_we),
    .wr_addr  (wb_addr),
    .wr_data  (acc_wd),
    .host_addr(rd_ch),
    .host_sel (rd_sel),
    .host_q   (rd_data)
  );

  for (genvar i = 0; i < NACC; i++) begin : g_unpack
    assign acc_old_a[i] = acc_old[i*ACC_W +: ACC_W];
  end

  for (genvar k = 0; k < NLAG; k++) begin : g_lane
    corr_lag_lane #(.DW(DW), .ACC_W(ACC_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (s1_valid),
      .x      (s1_x),
      .tap    (tap_q[LAG_TAP0+k]),
      .lag_old(acc_old_a[k]),
      .dly_old(acc_old_a[NLAG+k]),
      .lag_new(acc_new_a[k]),
      .dly_new(acc_new_a[NLAG+k])
    );
  end

  assign acc_new_a[NACC-1] = acc_old_a[NACC-1] + ACC_W'(s2_x);

  always_comb begin
    acc_wd = '0;
    if (!clearing)
      for (int i = 0; i < NACC; i++) acc_wd[i*ACC_W +: ACC_W] = acc_new_a[i];
  end

  // Assertions
  p_chan_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ch_cnt == LAST) |=> (ch_cnt == '0));
  p_chan_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ch_cnt != LAST) |=> (ch_cnt == $past(ch_cnt) + CW'(1)));
  p_chan_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(ch_cnt));
  p_wb_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_we && !clearing) |-> $past(accept && stage_en, 2));
  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !stage_en) |=> ##1 !wb_we);
  p_clear_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clearing) |-> ($past(clr_cnt) == LAST));
  p_csum_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_we && !clearing) |-> (acc_new_a[NACC-1] >= acc_old_a[NACC-1]));
  p_tap_no_collide_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_we && accept) |-> (wb_addr != ch_cnt));
endmodule

// File: tb/corr_mt_stage_bench.sv
module corr_mt_stage_bench;
  localparam int NCH = 4;
  localparam int STAGE = 1;
  localparam int DW = 4 + STAGE;
  localparam int CW = $clog2(NCH);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, in_valid, in_ready, stage_en;
  logic [DW-1:0] in_data;
  logic [CW-1:0] rd_ch;
  logic [3:0]    rd_sel;
  logic [63:0]   rd_data;

  corr_mt_stage #(.NCH(NCH), .STAGE(STAGE)) u_corr_mt_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .stage_en(stage_en), .rd_ch(rd_ch), .rd_sel(rd_sel),
    .rd_data(rd_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int unsigned     hist [NCH][8];
  longint unsigned macc [NCH][10];
  int mch = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_upd(int x, bit en);
    if (en) begin
      for (int k = 0; k < 4; k++) begin
        macc[mch][k]   += longint'(x) * longint'(hist[mch][4+k]);
        macc[mch][4+k] += longint'(hist[mch][4+k]);
      end
      macc[mch][8] += longint'(x);
      for (int i = 7; i > 0; i--) hist[mch][i] = hist[mch][i-1];
      hist[mch][0] = x;
    end
    mch = (mch + 1) % NCH;
  endfunction

  task automatic send(int x, bit en);
    @(negedge clk);
    in_valid = 1'b1; in_data = DW'(x); stage_en = en;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
    model_upd(x, en);
  endtask

  function automatic int val(int ch, int f);
    if (f == 12 || f == 13) return 31;
    return (ch * 11 + f * 7 + (f * f) % 13) % 32;
  endfunction

  task automatic frame(int f, bit en, bit gap);
    for (int ch = 0; ch < NCH; ch++) begin
      send(val(ch, f), en);
      if (gap && ch == 1) repeat (3) @(posedge clk);
    end
  endtask

  task automatic sweep(string tag);
    string rq;
    repeat (4) @(posedge clk);
    for (int ch = 0; ch < NCH; ch++)
      for (int sel = 0; sel < 10; sel++) begin
        rq = (sel < 4) ? "R3" : (sel < 8) ? "R4" : (sel == 8) ? "R5" : "R7";
        @(negedge clk);
        rd_ch = CW'(ch); rd_sel = 4'(sel);
        @(negedge clk);
        check($sformatf("%s %s ch%0d sel%0d", rq, tag, ch, sel), rd_data, macc[ch][sel]);
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    longint unsigned old;
    int n;
    for (int c = 0; c < NCH; c++) begin
      for (int i = 0; i < 8; i++) hist[c][i] = 0;
      for (int s = 0; s < 10; s++) macc[c][s] = 0;
    end
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; stage_en = 1'b0;
    rd_ch = '0; rd_sel = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check("R1 ready low at release", 64'(in_ready), 64'd0);
    n = 0;
    while (!in_ready && n < 1000) begin @(posedge clk); n++; @(negedge clk); end
    check("R1 clear length", 64'(n), 64'(NCH));
    sweep("R1 zero after clear");

    for (int f = 0; f < 12; f++) begin
      frame(f, 1'b1, (f % 3) == 0);
      if (f == 3) sweep("R2 R9 early");
    end
    sweep("R2 R9 full history");
    frame(12, 1'b1, 1'b0);
    frame(13, 1'b1, 1'b1);
    sweep("R3 max values");
    for (int f = 14; f < 17; f++) frame(f, 1'b0, f == 15);
    sweep("R6 disabled frames");
    for (int f = 17; f < 21; f++) frame(f, 1'b1, 1'b0);
    sweep("R6 resume");

    // Read and write-back on the same edge for channel 0.
    old = macc[0][8];
    @(negedge clk);
    rd_ch = '0; rd_sel = 4'd8;
    in_valid = 1'b1; in_data = DW'(19); stage_en = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    model_upd(19, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R8 R7 read after first edge", rd_data, old);
    @(posedge clk); @(negedge clk);
    check("R8 read on write-back edge", rd_data, old);
    @(posedge clk); @(negedge clk);
    check("R8 read after write-back", rd_data, old + 64'd19);
    for (int ch = 1; ch < NCH; ch++) send(val(ch, 21), 1'b1);
    sweep("R2 after collision");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule